// File: doc/BRIEF.md
# Hit-Channel Readout Manager

This block runs a multi-channel front end with no outside sequencing. Every channel works on its own. When a channel sees a hit strobe, the block records the moment of the hit from a shared free-running timestamp counter and marks that channel as waiting. A sequencer takes the waiting channels one at a time. For each one it drives a digital ramp code to an external comparator and ends the conversion when the comparator trips. It then emits one parallel frame that carries the channel's number, the stored timestamp and the converted value.

Acquisition never stops. Hits on idle channels are taken in every cycle, including cycles where another channel is being converted or read out. Each channel has one storage slot. A hit on a channel whose slot is already in use is dropped and counted in a saturating counter. Channels that were never hit produce no frames. When several channels are waiting, the lowest channel number goes first.

Top module: `hit_readout_mgr`

## Requirements
- R1: While reset is held and in the first cycle after it, `frame_vld_o` is 0, `conv_act_o` is 0 and `drop_cnt_o` is 0.
- R2: The timestamp counter is 0 during reset and adds one on every rising edge after reset. An accepted hit stores the counter value that was present at the edge that sampled it, which equals the number of edges since reset that came before that edge.
- R3: A hit on a channel with no pending entry is accepted in any cycle, including cycles in which another channel is converting.
- R4: When the sequencer is idle and channels are pending, it starts converting the lowest-numbered pending channel on the next edge.
- R5: In the first conversion cycle `ramp_o` is 0, and it rises by one each cycle after that. The conversion ends in the first cycle in which `cmp_i` is 1, or in the cycle `ramp_o` reaches its all-ones value (4095). The result is the value `ramp_o` held in that cycle.
- R6: Each accepted hit yields exactly one frame. `frame_vld_o` is high for one cycle, namely the cycle after the conversion ends. The frame layout is channel in bits [40:36], timestamp in [35:12] and conversion result in [11:0].
- R7: A channel is freed on the edge that produces its frame. A hit on a channel that is still pending, up to and including that edge, is dropped and leaves the stored timestamp unchanged.
- R8: `drop_cnt_o` rises by the number of hits dropped in each cycle and saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | 32 | Per-channel hit strobes, one bit per channel |
| cmp_i | input | 1 | Comparator result: ramp has reached the stored sample |
| conv_act_o | output | 1 | A conversion is in progress |
| conv_ch_o | output | 5 | Channel being converted |
| ramp_o | output | 12 | Ramp code driven to the comparator |
| frame_o | output | 41 | Frame: channel, timestamp, result |
| frame_vld_o | output | 1 | Frame valid, one cycle per frame |
| drop_cnt_o | output | 8 | Saturating count of dropped hits |

## Verification
The bound checker checks the following on every cycle: how the ramp starts and steps, that the converted channel stays fixed during a conversion, that every frame carries the channel and ramp value of the conversion that ended just before it, that the valid signal is a single-cycle pulse, and that the drop counter never falls and stays at its maximum once it gets there. The bench scenarios cover what depends on the history of hits. These are the captured timestamps, the lowest-first service order when hits arrive together or during a conversion, the dropping of repeat hits along with the timestamp they must not disturb, the exact drop counts, and the rule that channels that were never hit produce no frames.

// File: rtl/hcr_pkg.sv
`timescale 1ns/1ps
package hcr_pkg;
   typedef enum logic [0:0] {SQ_IDLE = 1'b0, SQ_CONV = 1'b1} seq_e;
endpackage

// File: rtl/hcr_hit_store.sv
`timescale 1ns/1ps
// Timestamp counter, per-channel pending flags and timestamp slots,
// and the saturating count of dropped hits.
module hcr_hit_store #(
   parameter int NCH   = 32,
   parameter int CH_W  = 5,
   parameter int TS_W  = 24,
   parameter int OVF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    hit_i,
   input  logic              rel_i,
   input  logic [CH_W-1:0]   rel_ch_i,
   output logic [NCH-1:0]    pend_o,
   output logic [TS_W-1:0]   rd_ts_o,
   output logic [OVF_W-1:0]  drop_cnt_o
);
   localparam int unsigned OVF_MAX = (2 ** OVF_W) - 1;

   logic [TS_W-1:0]  ts_cnt_q;
   logic [TS_W-1:0]  ts_slot_q [NCH];
   logic [NCH-1:0]   pend_q;
   logic [NCH-1:0]   drop_w;
   logic [OVF_W-1:0] ovf_q;
   logic [OVF_W-1:0] ovf_d;
   int unsigned      sum_w;

   always_ff @(posedge clk) begin
      if (!rst_n) ts_cnt_q <= '0;
      else        ts_cnt_q <= ts_cnt_q + TS_W'(1);
   end

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      assign drop_w[g] = hit_i[g] & pend_q[g];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend_q[g]    <= 1'b0;
            ts_slot_q[g] <= '0;
         end else if (hit_i[g] && !pend_q[g]) begin
            pend_q[g]    <= 1'b1;
            ts_slot_q[g] <= ts_cnt_q;
         end else if (rel_i && rel_ch_i == CH_W'(g)) begin
            pend_q[g]    <= 1'b0;
         end
      end
   end

   always_comb begin
      sum_w = int'(ovf_q) + $countones(drop_w);
      ovf_d = (sum_w > OVF_MAX) ? OVF_W'(OVF_MAX) : OVF_W'(sum_w);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ovf_q <= '0;
      else        ovf_q <= ovf_d;
   end

   assign pend_o     = pend_q;
   assign rd_ts_o    = ts_slot_q[rel_ch_i];
   assign drop_cnt_o = ovf_q;
endmodule

// File: rtl/hcr_pick.sv
`timescale 1ns/1ps
// Fixed-priority selector: lowest requesting index wins.
module hcr_pick #(
   parameter int NCH  = 32,
   parameter int CH_W = 5
) (
   input  logic [NCH-1:0]  req_i,
   output logic            any_o,
   output logic [CH_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = CH_W'(i);
      end
      any_o = |req_i;
   end
endmodule

// File: rtl/hcr_conv_seq.sv
`timescale 1ns/1ps
// Conversion and readout sequencer with ramp code and frame register.
module hcr_conv_seq
   import hcr_pkg::*;
#(
   parameter int CH_W  = 5,
   parameter int TS_W  = 24,
   parameter int ADC_W = 12,
   localparam int FRAME_W = CH_W + TS_W + ADC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_i,
   input  logic [CH_W-1:0]    pick_i,
   input  logic               cmp_i,
   input  logic [TS_W-1:0]    ts_i,
   output logic               act_o,
   output logic [CH_W-1:0]    ch_o,
   output logic [ADC_W-1:0]   ramp_o,
   output logic               rel_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               vld_o
);
   localparam logic [ADC_W-1:0] RAMP_MAX = '1;

   seq_e               st_q;
   logic [CH_W-1:0]    ch_q;
   logic [ADC_W-1:0]   ramp_q;
   logic [FRAME_W-1:0] frame_q;
   logic               vld_q;
   logic               done_w;

   assign done_w = (st_q == SQ_CONV) && (cmp_i || ramp_q == RAMP_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         ch_q    <= '0;
         ramp_q  <= '0;
         frame_q <= '0;
         vld_q   <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (any_i) begin
                  ch_q   <= pick_i;
                  ramp_q <= '0;
                  st_q   <= SQ_CONV;
               end
            end
            SQ_CONV: begin
               if (done_w) begin
                  frame_q <= {ch_q, ts_i, ramp_q};
                  vld_q   <= 1'b1;
                  st_q    <= SQ_IDLE;
               end else begin
                  ramp_q <= ramp_q + ADC_W'(1);
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign act_o   = (st_q == SQ_CONV);
   assign ch_o    = ch_q;
   assign ramp_o  = ramp_q;
   assign rel_o   = done_w;
   assign frame_o = frame_q;
   assign vld_o   = vld_q;
endmodule

// File: rtl/hit_readout_mgr.sv
`timescale 1ns/1ps
module hit_readout_mgr #(
   parameter int NCH   = 32,
   parameter int TS_W  = 24,
   parameter int ADC_W = 12,
   parameter int OVF_W = 8,
   localparam int CH_W    = $clog2(NCH),
   localparam int FRAME_W = CH_W + TS_W + ADC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NCH-1:0]     hit_i,
   input  logic               cmp_i,
   output logic               conv_act_o,
   output logic [CH_W-1:0]    conv_ch_o,
   output logic [ADC_W-1:0]   ramp_o,
   output logic [FRAME_W-1:0] frame_o,
   output logic               frame_vld_o,
   output logic [OVF_W-1:0]   drop_cnt_o
);
   if (NCH < 2) begin : g_bad_nch
      $error("hit_readout_mgr: NCH must be at least 2");
   end
   if (TS_W < 1 || ADC_W < 2) begin : g_bad_w
      $error("hit_readout_mgr: TS_W must be >= 1 and ADC_W >= 2");
   end
   if (OVF_W < 1 || OVF_W > 30) begin : g_bad_ovf
      $error("hit_readout_mgr: OVF_W must lie in 1..30");
   end

   logic [NCH-1:0]  pend_w;
   logic [TS_W-1:0] sel_ts_w;
   logic            any_w;
   logic [CH_W-1:0] pick_w;
   logic            rel_w;

   hcr_hit_store #(.NCH(NCH), .CH_W(CH_W), .TS_W(TS_W), .OVF_W(OVF_W)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit_i      (hit_i),
      .rel_i      (rel_w),
      .rel_ch_i   (conv_ch_o),
      .pend_o     (pend_w),
      .rd_ts_o    (sel_ts_w),
      .drop_cnt_o (drop_cnt_o)
   );

   hcr_pick #(.NCH(NCH), .CH_W(CH_W)) u_pick (
      .req_i (pend_w),
      .any_o (any_w),
      .idx_o (pick_w)
   );

   hcr_conv_seq #(.CH_W(CH_W), .TS_W(TS_W), .ADC_W(ADC_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .any_i   (any_w),
      .pick_i  (pick_w),
      .cmp_i   (cmp_i),
      .ts_i    (sel_ts_w),
      .act_o   (conv_act_o),
      .ch_o    (conv_ch_o),
      .ramp_o  (ramp_o),
      .rel_o   (rel_w),
      .frame_o (frame_o),
      .vld_o   (frame_vld_o)
   );
endmodule

// File: rtl/hcr_chk.sv
`timescale 1ns/1ps
module hcr_chk #(
   parameter int CH_W    = 5,
   parameter int ADC_W   = 12,
   parameter int OVF_W   = 8,
   parameter int FRAME_W = 41
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmp_i,
   input logic               conv_act_o,
   input logic [CH_W-1:0]    conv_ch_o,
   input logic [ADC_W-1:0]   ramp_o,
   input logic [FRAME_W-1:0] frame_o,
   input logic               frame_vld_o,
   input logic [OVF_W-1:0]   drop_cnt_o
);
   localparam logic [ADC_W-1:0] RAMP_TOP = '1;
   localparam logic [OVF_W-1:0] OVF_TOP  = '1;

   AST_RAMP_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_act_o) |-> ramp_o == '0); // R5
   AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_act_o && !cmp_i && ramp_o != RAMP_TOP) |=>
         (conv_act_o && ramp_o == $past(ramp_o) + ADC_W'(1))); // R5
   AST_CH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_act_o && $past(conv_act_o)) |-> $stable(conv_ch_o)); // R4
   AST_FRAME_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |-> (frame_o[FRAME_W-1 -: CH_W] == $past(conv_ch_o)
                       && frame_o[ADC_W-1:0] == $past(ramp_o)
                       && $past(conv_act_o) && !conv_act_o)); // R6
   AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld_o |=> !frame_vld_o); // R6
   AST_DROP_MONO: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt_o >= $past(drop_cnt_o)); // R8
   AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      drop_cnt_o == OVF_TOP |=> drop_cnt_o == OVF_TOP); // R8
endmodule

bind hit_readout_mgr hcr_chk #(
   .CH_W(CH_W), .ADC_W(ADC_W), .OVF_W(OVF_W), .FRAME_W(FRAME_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmp_i       (cmp_i),
   .conv_act_o  (conv_act_o),
   .conv_ch_o   (conv_ch_o),
   .ramp_o      (ramp_o),
   .frame_o     (frame_o),
   .frame_vld_o (frame_vld_o),
   .drop_cnt_o  (drop_cnt_o)
);

// File: tb/hit_readout_mgr_bench.sv
`timescale 1ns/1ps
module hit_readout_mgr_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] hits = '0;
   logic        cmp;
   logic        conv_act;
   logic [4:0]  conv_ch;
   logic [11:0] ramp;
   logic [40:0] frame;
   logic        frame_vld;
   logic [7:0]  drop_cnt;

   int level [32];
   int ts_seen [32];
   int cyc = 0;
   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct { logic [40:0] fr; string tag; } exp_t;
   exp_t sb_q [$];

   always #10 clk = ~clk;

   assign cmp = conv_act && (int'(ramp) >= level[conv_ch]);

   hit_readout_mgr u_hit_readout_mgr (
      .clk(clk), .rst_n(rst_n), .hit_i(hits), .cmp_i(cmp),
      .conv_act_o(conv_act), .conv_ch_o(conv_ch), .ramp_o(ramp),
      .frame_o(frame), .frame_vld_o(frame_vld), .drop_cnt_o(drop_cnt)
   );

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   // driver: hits on mask, records timestamp for the channels expected to be accepted
   task automatic hit(input logic [31:0] mask, input logic [31:0] fresh);
      @(negedge clk);
      hits = mask;
      @(posedge clk);
      for (int c = 0; c < 32; c++) if (fresh[c]) ts_seen[c] = cyc;
      @(negedge clk);
      hits = '0;
   endtask

   task automatic expect_frame(input int ch, input string tag);
      exp_t e;
      int adc;
      adc = (level[ch] > 4095) ? 4095 : level[ch];
      e.fr = {5'(ch), 24'(ts_seen[ch]), 12'(adc)};
      e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic wait_idle();
      int n = 0;
      do begin
         @(negedge clk);
         n++;
      end while ((sb_q.size() != 0 || conv_act) && n < 20000);
      repeat (3) @(negedge clk);
   endtask

   // monitor: pops expected frames and compares
   bit prev_vld = 1'b0;
   always @(negedge clk) begin
      if (rst_n && frame_vld) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R6 unexpected frame", 64'(frame), 64'(0));
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            check(frame == e.fr, e.tag, 64'(frame), 64'(e.fr));
         end
         check(!prev_vld, "R6 valid longer than one cycle", 64'(prev_vld), 64'(0));
      end
      prev_vld = frame_vld;
   end

   initial begin
      for (int c = 0; c < 32; c++) begin
         level[c] = 10 + c;
         ts_seen[c] = 0;
      end
      repeat (3) @(negedge clk);
      check(frame_vld == 1'b0 && conv_act == 1'b0 && drop_cnt == 8'd0, "R1 reset state",
            64'({frame_vld, conv_act, drop_cnt}), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(frame_vld == 1'b0 && conv_act == 1'b0 && drop_cnt == 8'd0, "R1 after reset",
            64'({frame_vld, conv_act, drop_cnt}), 64'(0));
      repeat (4) @(negedge clk);

      // single hit: timestamp, ramp result, layout
      level[7] = 20;
      hit(32'h1 << 7, 32'h1 << 7);
      expect_frame(7, "R2 R5 R6 single hit frame");
      wait_idle();

      // simultaneous hits served lowest first
      level[3] = 40; level[9] = 5; level[20] = 17;
      hit((32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20), (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20));
      expect_frame(3, "R4 order first ch3");
      expect_frame(9, "R4 order second ch9");
      expect_frame(20, "R4 order third ch20");
      wait_idle();

      // hits during a conversion are kept; lowest pending goes next
      level[20] = 300; level[15] = 8; level[2] = 12;
      hit(32'h1 << 20, 32'h1 << 20);
      expect_frame(20, "R3 ch20 converting");
      repeat (5) @(negedge clk);
      check(conv_act == 1'b1 && conv_ch == 5'd20, "R4 ch20 in conversion", 64'({conv_act, conv_ch}), 64'({1'b1, 5'd20}));
      hit(32'h1 << 15, 32'h1 << 15);
      repeat (3) @(negedge clk);
      hit(32'h1 << 2, 32'h1 << 2);
      expect_frame(2, "R3 R4 ch2 taken during conversion");
      expect_frame(15, "R3 R4 ch15 taken during conversion");
      wait_idle();

      // repeat hits on a pending channel are dropped
      level[11] = 200;
      hit(32'h1 << 11, 32'h1 << 11);
      expect_frame(11, "R7 original timestamp kept");
      repeat (5) @(negedge clk);
      for (int k = 0; k < 3; k++) hit(32'h1 << 11, 32'h0);
      check(drop_cnt == 8'd3, "R8 three drops counted", 64'(drop_cnt), 64'(3));
      wait_idle();
      check(drop_cnt == 8'd3, "R8 count after frame", 64'(drop_cnt), 64'(3));
      hit(32'h1 << 11, 32'h1 << 11);
      expect_frame(11, "R7 channel freed after its frame");
      wait_idle();

      // two drops in one cycle
      level[4] = 100; level[5] = 100;
      hit((32'h1 << 4) | (32'h1 << 5), (32'h1 << 4) | (32'h1 << 5));
      expect_frame(4, "R4 ch4 before ch5");
      expect_frame(5, "R4 ch5 after ch4");
      hit((32'h1 << 4) | (32'h1 << 5), 32'h0);
      check(drop_cnt == 8'd5, "R8 two drops in one cycle", 64'(drop_cnt), 64'(5));
      wait_idle();

      // ramp runs to full scale; drop counter saturates meanwhile
      level[31] = 5000;
      hit(32'h1 << 31, 32'h1 << 31);
      expect_frame(31, "R5 ramp reaches full scale");
      for (int k = 0; k < 260; k++) hit(32'h1 << 31, 32'h0);
      check(drop_cnt == 8'd255, "R8 saturates at 255", 64'(drop_cnt), 64'(255));
      wait_idle();
      check(drop_cnt == 8'd255, "R8 held at 255", 64'(drop_cnt), 64'(255));

      // comparator already high on first conversion cycle
      level[0] = 0;
      hit(32'h1, 32'h1);
      expect_frame(0, "R5 zero result");
      wait_idle();

      check(sb_q.size() == 0, "R6 all frames seen", 64'(sb_q.size()), 64'(0));
      repeat (20) @(negedge clk);
      check(frame_vld == 1'b0 && conv_act == 1'b0, "R6 no frame without hit", 64'({frame_vld, conv_act}), 64'(0));

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #3000000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule